// File: doc/BRIEF.md
# Serial Modular Exponentiation Decryptor

This block decrypts one message word by computing s = S^d mod N, where S is the received word, d the private exponent and N the modulus. All three operands and the result are 2^n bits wide. The width exponent n is chosen per job at run time, from 3 up to the synthesis-time limit `LOGW_MAX` (10 by default, so 8 to 1024 bits). A job starts with a one-cycle `start` pulse while the block is idle. The operands and n are captured on that edge.

Internally, a sequencer first reduces S modulo N. It then walks the exponent from its top bit down. For every exponent bit it squares an accumulator, and when the bit is 1 it also multiplies by the reduced base. Each modular product comes from a bit-serial unit that doubles, adds and conditionally subtracts N, one multiplier bit per clock, so the partial result always stays below N. When the exponent is used up, the result leaves on `msg` one bit per clock, most significant bit first. `frame` marks the bits that are valid.

Top module: `modexp_decrypt`

## Requirements
- R1: For n in 3..LOGW_MAX and 1 <= N < 2^(2^n), the word shifted out equals S^d mod N, with S and d taken as their low 2^n bits.
- R2: With n = 3, S = 27, d = 13 and N = 62, the output word is 29.
- R3: `msg` carries the result most significant bit first. It changes only on rising clock edges and delivers one bit per cycle for 2^n consecutive cycles.
- R4: `frame` is a registered output that stays high for exactly 2^n consecutive cycles per job.
- R5: `msg` is 0 whenever `frame` is 0.
- R6: `busy` goes high on the edge that accepts `start`, stays high while `frame` is high, and falls on the same edge as `frame`.
- R7: A `start` pulse while `busy` is high is ignored. The running job's result is unchanged and no extra frame follows.
- R8: With d = 0 the result is 1 mod N, which is 1 for N >= 2 and 0 for N = 1.
- R9: A message word S that is greater than or equal to N gives the same result as S mod N.
- R10: n, S, d and N are sampled only on the accepting `start` edge. Later changes on those inputs do not affect the running job.
- R11: After reset, `msg`, `frame` and `busy` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Pulse that launches a job when idle |
| width_log | input | $clog2(LOGW_MAX+1) | n: operand width is 2^n bits |
| cipher | input | 2^LOGW_MAX | Message word S |
| key_exp | input | 2^LOGW_MAX | Exponent d |
| modulus | input | 2^LOGW_MAX | Modulus N (nonzero) |
| msg | output | 1 | Serial result, MSB first |
| frame | output | 1 | High while msg carries result bits |
| busy | output | 1 | High from accepted start until frame falls |

## Verification
The bench builds the block with `LOGW_MAX = 5`, so the registers are 32 bits wide. It runs jobs with n = 3, 4 and 5. With these values every legal width, including the full register width, can be reached in a few thousand cycles per job, and a 64-bit reference model in the bench computes the expected results exactly. The small n = 3 case also brings the degenerate moduli (N = 1) and operands above N into reach with hand-checkable values.

// File: rtl/modexp_pkg.sv
// Package: shared types for the modular exponentiation decryptor.
// Assumes nothing beyond IEEE 1800-2017 enums.
package modexp_pkg;

    // Sequencer phases: each product has a launch cycle and a run phase.
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RED_GO,
        ST_RED_RUN,
        ST_SQ_GO,
        ST_SQ_RUN,
        ST_MU_GO,
        ST_MU_RUN,
        ST_SEND_GO,
        ST_SEND_WAIT
    } seq_state_t;

endpackage

// File: rtl/modmul_serial.sv
// Module: modmul_serial
// Computes prod = (op_a * op_b) mod modulus, scanning op_b MSB first over
// 2^width_log bits, one bit per clock (double, reduce, add, reduce).
// Assumes op_a < modulus and modulus >= 1. The go pulse is only given while
// idle. done pulses one cycle after the last step, and prod then holds.
module modmul_serial #(
    parameter int LOGW_MAX = 10,
    localparam int WMAX = 1 << LOGW_MAX,
    localparam int IW = LOGW_MAX,
    localparam int NW = $clog2(LOGW_MAX + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            go,
    input  logic [NW-1:0]   width_log,
    input  logic [WMAX-1:0] op_a,
    input  logic [WMAX-1:0] op_b,
    input  logic [WMAX-1:0] mod_val,
    output logic            done,
    output logic [WMAX-1:0] prod
);

    logic [WMAX-1:0] acc_r, a_r, b_r;
    logic [IW-1:0]   idx;
    logic            run;
    logic [IW:0]     wfull;
    logic [IW-1:0]   top_idx;
    logic [WMAX:0]   dbl, dbl_red, sum, sum_red, mod_ext;

    // Top bit index for the active width.
    assign wfull   = (IW + 1)'(1) << width_log;
    assign top_idx = IW'(wfull - (IW + 1)'(1));
    assign mod_ext = {1'b0, mod_val};

    // One interleaved step: 2R mod N, then plus A when the bit is set, mod N.
    always_comb begin
        dbl     = {acc_r, 1'b0};
        dbl_red = (dbl >= mod_ext) ? dbl - mod_ext : dbl;
        sum     = dbl_red + (b_r[idx] ? {1'b0, a_r} : '0);
        sum_red = (sum >= mod_ext) ? sum - mod_ext : sum;
    end

    // Operand capture, step register and bit counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_r <= '0;
            a_r   <= '0;
            b_r   <= '0;
            idx   <= '0;
            run   <= 1'b0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (go) begin
                acc_r <= '0;
                a_r   <= op_a;
                b_r   <= op_b;
                idx   <= top_idx;
                run   <= 1'b1;
            end else if (run) begin
                acc_r <= sum_red[WMAX-1:0];
                if (idx == '0) begin
                    run  <= 1'b0;
                    done <= 1'b1;
                end else begin
                    idx <= idx - 1'b1;
                end
            end
        end
    end

    assign prod = acc_r;

endmodule

// File: rtl/shift_out.sv
// Module: shift_out
// Sends the low 2^width_log bits of value on msg, MSB first, one per clock,
// with frame high for exactly that many cycles. last flags the final cycle.
// Assumes load is pulsed only while frame is low.
module shift_out #(
    parameter int LOGW_MAX = 10,
    localparam int WMAX = 1 << LOGW_MAX,
    localparam int IW = LOGW_MAX,
    localparam int NW = $clog2(LOGW_MAX + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [NW-1:0]   width_log,
    input  logic [WMAX-1:0] value,
    output logic            msg,
    output logic            frame,
    output logic            last
);

    logic [WMAX-1:0] sh;
    logic [WMAX-1:0] aligned;
    logic [IW-1:0]   rem;
    logic [IW:0]     wfull;
    logic [IW:0]     shamt;

    // Left-align the active field so its MSB sits at the top of the register.
    assign wfull   = (IW + 1)'(1) << width_log;
    assign shamt   = (IW + 1)'(WMAX) - wfull;
    assign aligned = value << shamt;
    assign last    = frame && (rem == '0);

    // Shift register, remaining-bit counter and registered outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh    <= '0;
            rem   <= '0;
            msg   <= 1'b0;
            frame <= 1'b0;
        end else if (load) begin
            msg   <= aligned[WMAX-1];
            sh    <= aligned << 1;
            rem   <= IW'(wfull - (IW + 1)'(1));
            frame <= 1'b1;
        end else if (frame) begin
            if (rem == '0) begin
                frame <= 1'b0;
                msg   <= 1'b0;
            end else begin
                rem <= rem - 1'b1;
                msg <= sh[WMAX-1];
                sh  <= sh << 1;
            end
        end
    end

endmodule

// File: rtl/exp_seq.sv
// Module: exp_seq
// Runs the square-and-multiply schedule. It reduces S mod N, then for each
// exponent bit from the top it squares the accumulator and multiplies by the
// base when the bit is 1. Finally it hands the result to the serializer.
// Assumes modulus is nonzero. start is accepted only in idle.
module exp_seq
    import modexp_pkg::*;
#(
    parameter int LOGW_MAX = 10,
    localparam int WMAX = 1 << LOGW_MAX,
    localparam int IW = LOGW_MAX,
    localparam int NW = $clog2(LOGW_MAX + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [NW-1:0]   width_log_in,
    input  logic [WMAX-1:0] cipher,
    input  logic [WMAX-1:0] key_exp,
    input  logic [WMAX-1:0] modulus,
    input  logic            mm_done,
    input  logic [WMAX-1:0] mm_prod,
    input  logic            ser_last,
    output logic            mm_go,
    output logic [WMAX-1:0] mm_a,
    output logic [WMAX-1:0] mm_b,
    output logic [WMAX-1:0] mod_r,
    output logic [NW-1:0]   wl_r,
    output logic            ser_load,
    output logic [WMAX-1:0] result,
    output logic            busy
);

    seq_state_t      state;
    logic [WMAX-1:0] s_r, d_r, base_r, acc_r, one_v;
    logic [IW-1:0]   eidx;
    logic [IW:0]     wfull;

    assign wfull = (IW + 1)'(1) << wl_r;
    assign one_v = (mod_r == WMAX'(1)) ? '0 : WMAX'(1);

    // Operand routing for the product unit, by launch state.
    always_comb begin
        mm_go = (state == ST_RED_GO) || (state == ST_SQ_GO) || (state == ST_MU_GO);
        mm_a  = acc_r;
        mm_b  = acc_r;
        case (state)
            ST_RED_GO: begin mm_a = one_v;  mm_b = s_r;   end
            ST_MU_GO:  begin mm_a = base_r; mm_b = acc_r; end
            default:   begin mm_a = acc_r;  mm_b = acc_r; end
        endcase
    end

    assign ser_load = (state == ST_SEND_GO);
    assign result   = acc_r;
    assign busy     = (state != ST_IDLE);

    // Phase sequencing, operand capture and accumulator updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            s_r    <= '0;
            d_r    <= '0;
            mod_r  <= '0;
            wl_r   <= '0;
            base_r <= '0;
            acc_r  <= '0;
            eidx   <= '0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    s_r   <= cipher;
                    d_r   <= key_exp;
                    mod_r <= modulus;
                    wl_r  <= width_log_in;
                    state <= ST_RED_GO;
                end
                ST_RED_GO: state <= ST_RED_RUN;
                ST_RED_RUN: if (mm_done) begin
                    base_r <= mm_prod;
                    acc_r  <= one_v;
                    eidx   <= IW'(wfull - (IW + 1)'(1));
                    state  <= ST_SQ_GO;
                end
                ST_SQ_GO: state <= ST_SQ_RUN;
                ST_SQ_RUN: if (mm_done) begin
                    acc_r <= mm_prod;
                    if (d_r[eidx]) begin
                        state <= ST_MU_GO;
                    end else if (eidx == '0) begin
                        state <= ST_SEND_GO;
                    end else begin
                        eidx  <= eidx - 1'b1;
                        state <= ST_SQ_GO;
                    end
                end
                ST_MU_GO: state <= ST_MU_RUN;
                ST_MU_RUN: if (mm_done) begin
                    acc_r <= mm_prod;
                    if (eidx == '0) begin
                        state <= ST_SEND_GO;
                    end else begin
                        eidx  <= eidx - 1'b1;
                        state <= ST_SQ_GO;
                    end
                end
                ST_SEND_GO: state <= ST_SEND_WAIT;
                ST_SEND_WAIT: if (ser_last) state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/modexp_decrypt.sv
// Module: modexp_decrypt (top)
// Decrypts one word, s = S^d mod N, at a run-time width of 2^width_log bits,
// and shifts the result out MSB first under frame.
// Assumes 3 <= width_log <= LOGW_MAX, modulus nonzero, and modulus free of
// bits above the active width.
module modexp_decrypt #(
    parameter int LOGW_MAX = 10,
    localparam int WMAX = 1 << LOGW_MAX,
    localparam int NW = $clog2(LOGW_MAX + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [NW-1:0]   width_log,
    input  logic [WMAX-1:0] cipher,
    input  logic [WMAX-1:0] key_exp,
    input  logic [WMAX-1:0] modulus,
    output logic            msg,
    output logic            frame,
    output logic            busy
);

    logic            mm_go, mm_done, ser_load, ser_last;
    logic [WMAX-1:0] mm_a, mm_b, mm_prod, mod_r, result;
    logic [NW-1:0]   wl_r;

    exp_seq #(.LOGW_MAX(LOGW_MAX)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .width_log_in(width_log),
        .cipher(cipher), .key_exp(key_exp), .modulus(modulus),
        .mm_done(mm_done), .mm_prod(mm_prod), .ser_last(ser_last),
        .mm_go(mm_go), .mm_a(mm_a), .mm_b(mm_b), .mod_r(mod_r), .wl_r(wl_r),
        .ser_load(ser_load), .result(result), .busy(busy)
    );

    modmul_serial #(.LOGW_MAX(LOGW_MAX)) u_mul (
        .clk(clk), .rst_n(rst_n), .go(mm_go), .width_log(wl_r),
        .op_a(mm_a), .op_b(mm_b), .mod_val(mod_r),
        .done(mm_done), .prod(mm_prod)
    );

    shift_out #(.LOGW_MAX(LOGW_MAX)) u_out (
        .clk(clk), .rst_n(rst_n), .load(ser_load), .width_log(wl_r),
        .value(result), .msg(msg), .frame(frame), .last(ser_last)
    );

endmodule

// File: rtl/modexp_chk.sv
// Module: modexp_chk
// Port-level protocol checks for modexp_decrypt, attached by bind.
// Keeps its own copy of the accepted width and its own frame-length counter.
module modexp_chk #(
    parameter int LOGW_MAX = 10,
    localparam int IW = LOGW_MAX,
    localparam int NW = $clog2(LOGW_MAX + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic [NW-1:0] width_log,
    input logic          msg,
    input logic          frame,
    input logic          busy
);

    logic [IW:0] w_cap;
    logic [IW:0] frame_len;

    // Width of the job accepted on an idle start, and frame-high cycle count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w_cap     <= '0;
            frame_len <= '0;
        end else begin
            if (start && !busy) w_cap <= (IW + 1)'(1) << width_log;
            frame_len <= frame ? frame_len + 1'b1 : '0;
        end
    end

    assert_frame_in_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        frame |-> busy);
    assert_busy_ends_with_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(frame) |-> $fell(busy));
    assert_busy_needs_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));
    assert_msg_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !frame |-> !msg);
    assert_frame_not_long_R4: assert property (@(posedge clk) disable iff (!rst_n)
        frame |-> (frame_len < w_cap));
    assert_frame_exact_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(frame) |-> (frame_len == w_cap));

endmodule

bind modexp_decrypt modexp_chk #(.LOGW_MAX(LOGW_MAX)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .width_log(width_log),
    .msg(msg), .frame(frame), .busy(busy)
);

// File: tb/tb_modexp_decrypt.sv
// Scoreboard bench: the driver queues reference results, and a monitor
// collects each serial frame and compares it.
module tb_modexp_decrypt;

    localparam int LOGW = 5;
    localparam int WMAX = 1 << LOGW;
    localparam int NW = $clog2(LOGW + 1);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic [NW-1:0]   width_log = '0;
    logic [WMAX-1:0] cipher = '0, key_exp = '0, modulus = '0;
    logic            msg, frame, busy;

    int checks = 0;
    int errors = 0;
    int frames = 0;
    int jobs = 0;
    bit done_flag = 0;

    typedef struct {
        longint unsigned val;
        int              w;
        string           req;
    } exp_t;
    exp_t sb_q[$];

    always #4 clk = ~clk;

    modexp_decrypt #(.LOGW_MAX(LOGW)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .width_log(width_log),
        .cipher(cipher), .key_exp(key_exp), .modulus(modulus),
        .msg(msg), .frame(frame), .busy(busy)
    );

    task automatic chk(bit ok, string req, string what,
                       longint unsigned act, longint unsigned expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    // Reference model: square-and-multiply over the low 2^nlog bits.
    function automatic longint unsigned ref_modexp(int nlog, longint unsigned s,
                                                   longint unsigned d,
                                                   longint unsigned m);
        int w = 1 << nlog;
        longint unsigned msk = (64'd1 << w) - 1;
        longint unsigned b = (s & msk) % m;
        longint unsigned r = 1 % m;
        longint unsigned dm = d & msk;
        for (int i = w - 1; i >= 0; i--) begin
            r = (r * r) % m;
            if (dm[i]) r = (r * b) % m;
        end
        return r;
    endfunction

    // Driver: launch a job, queue its expected word, then scramble inputs (R10).
    task automatic run_job(int nlog, longint unsigned s, longint unsigned d,
                           longint unsigned m, string req);
        exp_t e;
        while (busy) @(negedge clk);
        width_log = NW'(nlog);
        cipher    = WMAX'(s);
        key_exp   = WMAX'(d);
        modulus   = WMAX'(m);
        start     = 1'b1;
        e.val = ref_modexp(nlog, s, d, m);
        e.w   = 1 << nlog;
        e.req = req;
        sb_q.push_back(e);
        jobs++;
        @(negedge clk);
        start     = 1'b0;
        cipher    = '1;
        key_exp   = 32'h5A5A_A5A5;
        modulus   = 32'd3;
        width_log = NW'(4);
        chk(busy == 1'b1, "R6", "busy after accepted start", busy, 1);
    endtask

    // Monitor: gather frame bits at falling edges and compare at frame end.
    logic [63:0] got;
    int          cnt;
    bit          in_fr = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (frame) begin
                if (!in_fr) begin
                    in_fr = 1;
                    cnt = 0;
                    got = '0;
                end
                got = {got[62:0], msg};
                cnt++;
                if (!busy) chk(0, "R6", "busy low during frame", busy, 1);
            end else if (in_fr) begin
                exp_t e;
                in_fr = 0;
                frames++;
                if (sb_q.size() == 0) begin
                    chk(0, "R7", "unexpected frame", frames, jobs);
                end else begin
                    e = sb_q.pop_front();
                    chk(got == e.val, e.req, "result word (R1, R3 MSB first)", got, e.val);
                    chk(cnt == e.w, "R4", "frame length", longint'(cnt), longint'(e.w));
                end
                chk(busy == 1'b0, "R6", "busy falls with frame", busy, 0);
                chk(msg == 1'b0, "R5", "msg low after frame", msg, 0);
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(frame == 1'b0, "R11", "frame after reset", frame, 0);
        chk(msg == 1'b0, "R11", "msg after reset", msg, 0);
        chk(busy == 1'b0, "R11", "busy after reset", busy, 0);

        run_job(3, 27, 13, 62, "R2");
        run_job(4, 16'hBEEF, 16'h1234, 16'hFFF1, "R1");
        run_job(3, 200, 7, 57, "R9");
        run_job(4, 123, 0, 1000, "R8");
        run_job(3, 5, 3, 1, "R8");

        // R7: a start pulse mid-job with other operands must not disturb it.
        run_job(3, 99, 77, 101, "R7");
        repeat (20) @(negedge clk);
        width_log = NW'(3);
        cipher    = 32'd2;
        key_exp   = 32'd1;
        modulus   = 32'd7;
        start     = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R7", "still busy after ignored start", busy, 1);

        run_job(5, 32'h1234_5678, 32'h9ABC_DEF1, 32'hFFFF_FFFB, "R1");
        run_job(5, 32'hFFFF_FFFF, 32'h0000_0101, 32'd1_000_003, "R9");
        run_job(4, 16'h00FF, 16'hFFFF, 16'h0002, "R10");

        while (sb_q.size() != 0 || busy) @(negedge clk);
        repeat (40) @(negedge clk);
        chk(frames == jobs, "R7", "frame count equals job count",
            longint'(frames), longint'(jobs));
        if (!done_flag) begin
            done_flag = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            done_flag = 1;
            chk(0, "R1", "watchdog expired", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule